// File: doc/BRIEF.md
# Windowed Watchdog Timer with Write-Once Configuration

This block is a 12-bit watchdog that counts down by one on each pulse of a slow-clock enable. Software services it with a restart pulse. A restart is accepted only once the count has dropped to or below a programmable delta value. A restart that comes too early is treated as a fault, and so is letting the count run out. A fault can raise a sticky interrupt line, a fixed-length reset pulse, or both. The two enable bits choose which.

All configuration sits in one 32-bit mode register. It leaves reset with a safe preset, and it accepts exactly one write. After that write every further write is dropped, while the current value can always be read back. The counter can be switched off entirely. It can also freeze while the processor is in debug state or the system is idle, each under its own halt bit.

Top module: `wdw_window_top`

## Requirements
- R1: After reset the mode read-back is 0x3FFF2FFF, the count is 0xFFF, and irq and wd_reset are low.
- R2: The first mode write is stored. The count takes the written reload field (bits 11:0) on the next clock.
- R3: Every mode write after the first leaves the read-back and the count unchanged.
- R4: With the counter running and not halted, each tick lowers the count by one. Without a tick the count holds.
- R5: A tick at count 0 is an underflow fault, and the count reloads from the reload field.
- R6: A restart while count <= delta (bits 27:16) reloads the count and raises no fault.
- R7: A restart while count > delta is an error fault, and the count is left unchanged.
- R8: A fault sets irq on the next clock only when bit 12 is 1. irq stays high until a stat_rd pulse clears it.
- R9: A fault drives wd_reset high for RST_LEN clocks, starting on the next clock, only when bit 13 is 1.
- R10: With bit 15 set the count holds, and neither ticks nor restarts produce faults.
- R11: With bit 28 set, ticks are ignored while dbg_state is high. With bit 28 clear they still count.
- R12: With bit 29 set, ticks are ignored while idle_state is high.
- R13: A restart and a tick in the same cycle are handled as a restart alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow-clock enable, one cycle wide |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 32 | Mode register write data |
| cfg_rdata | output | 32 | Mode register read-back |
| restart | input | 1 | Restart request pulse |
| stat_rd | input | 1 | Status read pulse, clears irq |
| dbg_state | input | 1 | Processor in debug state |
| idle_state | input | 1 | System in idle state |
| count | output | 12 | Current counter value |
| irq | output | 1 | Sticky fault interrupt |
| wd_reset | output | 1 | Watchdog reset pulse |

## Verification
Restarts are issued both above and at or below the delta bound. This tells a correct window apart from one that is off by one or reversed. Ticks are applied at count 0 and at count 1, and in the same cycle as a restart, to separate underflow reload from ordinary decrement and to show which request wins. Several configurations, each loaded after its own reset, alter the enable, disable and halt bits individually. A second write follows each first write, showing that the lock holds.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam int CW = 12;
  localparam logic [31:0] MODE_RST = 32'h3FFF_2FFF;

  typedef struct packed {
    logic [1:0]    rsvd_hi;
    logic          idle_halt;
    logic          dbg_halt;
    logic [CW-1:0] delta;
    logic          off;
    logic          rsvd_mid;
    logic          rst_en;
    logic          irq_en;
    logic [CW-1:0] reload;
  } mode_t;

  function automatic logic in_window(input logic [CW-1:0] cnt, input logic [CW-1:0] delta);
    return cnt <= delta;
  endfunction

  function automatic logic halted(input logic dbg_h, input logic idle_h,
                                  input logic dbg_s, input logic idle_s);
    return (dbg_h & dbg_s) | (idle_h & idle_s);
  endfunction
endpackage

// File: rtl/wdw_mode_reg.sv
module wdw_mode_reg
  import wdw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output mode_t       mode,
  output logic        accept
);
  logic locked;

  assign accept = wr_en & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= mode_t'(MODE_RST);
      locked <= 1'b0;
    end else if (accept) begin
      mode   <= mode_t'(wr_data);
      locked <= 1'b1;
    end
  end

  assert_locked_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> $stable(mode));
endmodule

// File: rtl/wdw_counter.sv
module wdw_counter
  import wdw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload,
  input  logic [CW-1:0] delta,
  input  logic          off,
  input  logic          dbg_halt,
  input  logic          idle_halt,
  input  logic          tick,
  input  logic          restart,
  input  logic          dbg_state,
  input  logic          idle_state,
  output logic [CW-1:0] cnt,
  output logic          uflow_ev,
  output logic          err_ev,
  output logic          fault
);
  logic run, ok_ev, dec_ev;

  assign run      = ~off & ~load;
  assign ok_ev    = run & restart & in_window(cnt, delta);
  assign err_ev   = run & restart & ~in_window(cnt, delta);
  assign dec_ev   = run & ~restart & tick & ~halted(dbg_halt, idle_halt, dbg_state, idle_state);
  assign uflow_ev = dec_ev & (cnt == '0);
  assign fault    = uflow_ev | err_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= MODE_RST[CW-1:0];
    else if (load)               cnt <= load_val;
    else if (ok_ev || uflow_ev)  cnt <= reload;
    else if (dec_ev)             cnt <= cnt - 1'b1;
  end

  assert_err_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_ev |=> cnt == $past(cnt));
  assert_uflow_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_ev |=> cnt == $past(reload));
  assert_off_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (off && !load) |=> cnt == $past(cnt));
endmodule

// File: rtl/wdw_fault_out.sv
module wdw_fault_out #(
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic irq_en,
  input  logic rst_en,
  input  logic stat_rd,
  output logic irq,
  output logic wd_reset
);
  localparam int RW = $clog2(RST_LEN + 1);
  localparam logic [RW-1:0] RLEN = RW'(RST_LEN);
  logic [RW-1:0] rcnt;

  assign wd_reset = rcnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irq <= 1'b0;
    else if (fault && irq_en)  irq <= 1'b1;
    else if (stat_rd)          irq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rcnt <= '0;
    else if (fault && rst_en)  rcnt <= RLEN;
    else if (rcnt != '0)       rcnt <= rcnt - 1'b1;
  end

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fault && irq_en));
  assert_reset_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_reset) |-> $past(fault && rst_en));
endmodule

// File: rtl/wdw_window_top.sv
module wdw_window_top #(
  parameter int RST_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        restart,
  input  logic        stat_rd,
  input  logic        dbg_state,
  input  logic        idle_state,
  output logic [11:0] count,
  output logic        irq,
  output logic        wd_reset
);
  import wdw_pkg::*;

  mode_t         mode;
  logic          wr_accept, uflow_ev, err_ev, fault;
  logic [CW-1:0] load_val;

  assign cfg_rdata = 32'(mode);
  assign load_val  = cfg_wdata[CW-1:0];

  wdw_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .mode(mode), .accept(wr_accept)
  );

  wdw_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(wr_accept), .load_val(load_val),
    .reload(mode.reload), .delta(mode.delta), .off(mode.off),
    .dbg_halt(mode.dbg_halt), .idle_halt(mode.idle_halt),
    .tick(tick), .restart(restart), .dbg_state(dbg_state), .idle_state(idle_state),
    .cnt(count), .uflow_ev(uflow_ev), .err_ev(err_ev), .fault(fault)
  );

  wdw_fault_out #(.RST_LEN(RST_LEN)) u_fault (
    .clk(clk), .rst_n(rst_n), .fault(fault), .irq_en(mode.irq_en),
    .rst_en(mode.rst_en), .stat_rd(stat_rd), .irq(irq), .wd_reset(wd_reset)
  );

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> count == $past(cfg_wdata[CW-1:0]));
endmodule

// File: tb/test_wdw_window_top.sv
module test_wdw_window_top;
  localparam int RL = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, restart = 0, stat_rd = 0, dbg = 0, idle = 0, we = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [11:0] count;
  logic irq, wd_reset;
  int vecs = 0, errs = 0;

  // behavioural reference state
  logic [31:0] m_mode;
  bit m_lock, m_irq, m_f;
  int m_cnt, m_rc;

  wdw_window_top #(.RST_LEN(RL)) i_wdw_window_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(we), .cfg_wdata(wdata),
    .cfg_rdata(rdata), .restart(restart), .stat_rd(stat_rd), .dbg_state(dbg),
    .idle_state(idle), .count(count), .irq(irq), .wd_reset(wd_reset));

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 32'h3FFF2FFF; m_lock = 0; m_cnt = 4095; m_irq = 0; m_rc = 0;
    end else begin
      m_f = 0;
      if (we && !m_lock) begin
        m_mode = wdata; m_lock = 1; m_cnt = int'(wdata[11:0]);
      end else if (!m_mode[15]) begin
        if (restart) begin
          if (m_cnt <= int'(m_mode[27:16])) m_cnt = int'(m_mode[11:0]);
          else m_f = 1;
        end else if (tick && !((m_mode[28] && dbg) || (m_mode[29] && idle))) begin
          if (m_cnt == 0) begin m_f = 1; m_cnt = int'(m_mode[11:0]); end
          else m_cnt = m_cnt - 1;
        end
      end
      if (m_f && m_mode[12]) m_irq = 1;
      else if (stat_rd) m_irq = 0;
      if (m_f && m_mode[13]) m_rc = RL;
      else if (m_rc > 0) m_rc = m_rc - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all;
    chk("R2 R3 read-back vs model", rdata, m_mode);
    chk("R4 count vs model", 32'(count), 32'(m_cnt));
    chk("R8 irq vs model", 32'(irq), 32'(m_irq));
    chk("R9 wd_reset vs model", 32'(wd_reset), 32'(m_rc != 0));
  endtask

  task automatic step(input bit tk = 0, input bit rs = 0, input bit sr = 0,
                      input bit d = 0, input bit i = 0, input bit w = 0,
                      input logic [31:0] wd = 0);
    tick = tk; restart = rs; stat_rd = sr; dbg = d; idle = i; we = w; wdata = wd;
    @(negedge clk);
    compare_all();
    tick = 0; restart = 0; stat_rd = 0; dbg = 0; idle = 0; we = 0;
  endtask

  task automatic do_reset;
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    // Phase A: reset defaults
    do_reset();
    chk("R1 read-back", rdata, 32'h3FFF2FFF);
    chk("R1 count", 32'(count), 32'hFFF);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 wd_reset", 32'(wd_reset), 0);
    step(.tk(1));          chk("R4 decrement", 32'(count), 32'hFFE);
    step();                chk("R4 hold without tick", 32'(count), 32'hFFE);
    step(.tk(1), .d(1));   chk("R11 debug halt", 32'(count), 32'hFFE);
    step(.tk(1), .i(1));   chk("R12 idle halt", 32'(count), 32'hFFE);
    step(.rs(1));          chk("R6 restart in window", 32'(count), 32'hFFF);
    chk("R6 no fault", 32'(wd_reset), 0);

    // Phase B: reload 5, delta 2, both fault outputs enabled, no halts
    do_reset();
    step(.w(1), .wd(32'h0002_3005));
    chk("R2 read-back", rdata, 32'h0002_3005);
    chk("R2 count loaded", 32'(count), 5);
    step(.w(1), .wd(32'h0000_0000));
    chk("R3 write ignored", rdata, 32'h0002_3005);
    chk("R3 count kept", 32'(count), 5);
    step(.rs(1));
    chk("R7 early restart count kept", 32'(count), 5);
    chk("R8 irq on error", 32'(irq), 1);
    chk("R9 reset on error", 32'(wd_reset), 1);
    step(); step(); step();
    chk("R9 reset still high", 32'(wd_reset), 1);
    step();
    chk("R9 reset ends", 32'(wd_reset), 0);
    chk("R8 irq sticky", 32'(irq), 1);
    step(.sr(1));          chk("R8 irq cleared", 32'(irq), 0);
    for (int k = 0; k < 3; k++) step(.tk(1));
    chk("R4 count at delta", 32'(count), 2);
    step(.rs(1));
    chk("R6 restart reloads", 32'(count), 5);
    chk("R6 no irq", 32'(irq), 0);
    for (int k = 0; k < 5; k++) step(.tk(1));
    chk("R4 count at zero", 32'(count), 0);
    step(.tk(1));
    chk("R5 underflow reload", 32'(count), 5);
    chk("R5 underflow irq", 32'(irq), 1);
    step(.sr(1));
    for (int k = 0; k < 4; k++) step();
    step(.tk(1), .d(1));   chk("R11 halt bit clear runs", 32'(count), 4);
    step(.tk(1)); step(.tk(1));
    step(.tk(1), .rs(1));  chk("R13 restart wins", 32'(count), 5);

    // Phase C: disabled
    do_reset();
    step(.w(1), .wd(32'h0000_B005));
    for (int k = 0; k < 3; k++) step(.tk(1));
    chk("R10 count held", 32'(count), 5);
    step(.rs(1));
    chk("R10 no irq", 32'(irq), 0);
    chk("R10 no reset", 32'(wd_reset), 0);

    // Phase D: faults with outputs disabled
    do_reset();
    step(.w(1), .wd(32'h0001_0001));
    step(.tk(1)); step(.tk(1));
    chk("R5 reload after underflow", 32'(count), 1);
    chk("R8 irq masked", 32'(irq), 0);
    chk("R9 reset masked", 32'(wd_reset), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule